// File: doc/BRIEF.md
# Transport Packet Ring Buffer Writer

This block receives a byte stream of transport packets and lays each packet into its own fixed-size slot of a circular buffer held in external memory. A packet is 188 bytes long. Its slot is 192 bytes, which is the packet length rounded up to the next multiple of the 8-byte memory word. The block packs the incoming bytes into 64-bit words and issues them on a simple write port. The tail of each slot is filled with zeros.

Software gives the buffer a base address and a top address (base + size − 1). A load pulse moves the write pointer to base. The consumer reports how far it has read through a read-pointer input, and it signals a wrap by setting that pointer back to base. The block publishes its write pointer only after a slot is complete. It reports occupancy and a full flag. When no slot is free, it drops a whole packet and counts the drop. A single enable input gates all writing.

Top module: `ts_ring_writer`

## Requirements
- R1: Every stored packet takes one slot of 192 bytes (188 payload bytes padded to a multiple of 8), and the write pointer moves forward by exactly 192 for each stored packet.
- R2: Memory writes are 64-bit words at 8-byte-aligned byte addresses. Packet byte i goes to address slot_start + i, carried on data bits [8*(i mod 8)+7 : 8*(i mod 8)].
- R3: Bytes 188 to 191 of every slot are written as zero.
- R4: The write pointer changes one cycle after the final word of a slot appears on the write port, and at no other time except a load.
- R5: When the next slot start would lie above the top address, the write pointer returns to the base address.
- R6: The buffer counts as full when the next slot start equals the read pointer. A start-of-packet that arrives while full discards that whole packet: no memory write, no pointer move, and the overflow count rises by one.
- R7: Occupancy is write pointer minus read pointer, plus (top − base + 1) when that difference is negative. Occupancy and the full flag are registered from the current pointers.
- R8: Deasserting enable stops memory writes from the next cycle on. A partly written packet is abandoned, and the write pointer does not move.
- R9: Bytes that arrive without a started packet are ignored. A start-of-packet in the middle of a packet restarts writing at the start of the same slot.
- R10: A load pulse sets the write pointer to the programmed base address.
- R11: During reset the write strobe, write pointer, occupancy, full flag and overflow count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; gates all writing |
| cfg_load | input | 1 | Load pulse: write pointer set to base |
| cfg_base | input | ADDR_W | Buffer base byte address |
| cfg_top | input | ADDR_W | Last byte address of the buffer |
| rd_ptr | input | ADDR_W | Consumer read pointer |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first byte of a packet |
| in_data | input | 8 | Input byte |
| mem_we | output | 1 | Word write strobe |
| mem_addr | output | ADDR_W | Byte address of the word being written |
| mem_wdata | output | 8*WORD_BYTES | Word data, lowest address in the low lane |
| wr_ptr | output | ADDR_W | Published write pointer |
| occupancy | output | ADDR_W | Bytes held between read and write pointers |
| full | output | 1 | No free slot for another packet |
| ovf_count | output | CNT_W | Count of discarded packets |

## Verification
A byte accepted at one edge appears on the write port right after that edge. If it is the final byte of a slot, the write pointer, occupancy and full flag follow one edge later. The bench drives and samples at the falling edge. It reads the write strobe in the half cycle after the last byte is taken and reads the pointer one full cycle after that. After a read-pointer change, it waits two falling edges before it checks status. A memory model in the bench records every word write, and whole slots are compared byte for byte against a pattern computed from the packet tag. The memory is filled with 0xAA beforehand, so missing zero fill or a stray write shows up.

// File: rtl/ts_ring_pkg.sv
package ts_ring_pkg;
  // Round a packet length up to a whole number of memory words.
  function automatic int slot_bytes(int pkt_len, int word_bytes);
    return ((pkt_len + word_bytes - 1) / word_bytes) * word_bytes;
  endfunction
endpackage

// File: rtl/ts_word_packer.sv
module ts_word_packer #(
  parameter int PKT_LEN    = 188,
  parameter int WORD_BYTES = 8,
  parameter int ADDR_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    abort,
  input  logic                    in_valid,
  input  logic                    in_sop,
  input  logic [7:0]              in_data,
  input  logic                    room,
  input  logic [ADDR_W-1:0]       slot_base,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_BYTES*8-1:0] mem_wdata,
  output logic                    done,
  output logic                    drop
);
  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam int OFF_W  = $clog2(PKT_LEN);
  localparam int DATA_W = WORD_BYTES * 8;

  logic              active;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] acc;

  logic [OFF_W-1:0]  cur_off;
  logic [LANE_W-1:0] lane;
  logic              take, last, word_end;
  logic [DATA_W-1:0] merged;
  logic [ADDR_W-1:0] word_addr;

  always_comb begin
    cur_off   = in_sop ? '0 : off;
    lane      = cur_off[LANE_W-1:0];
    take      = !abort && in_valid && (in_sop ? room : active);
    last      = (cur_off == OFF_W'(PKT_LEN - 1));
    word_end  = last || (lane == LANE_W'(WORD_BYTES - 1));
    word_addr = slot_base + ADDR_W'({cur_off[OFF_W-1:LANE_W], {LANE_W{1'b0}}});
    merged    = (lane == '0) ? '0 : acc;
    merged[int'(lane)*8 +: 8] = in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      off       <= '0;
      acc       <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      drop      <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      done   <= 1'b0;
      drop   <= 1'b0;
      if (abort) begin
        active <= 1'b0;
      end else if (in_valid && in_sop && !room) begin
        active <= 1'b0;
        drop   <= 1'b1;
      end else if (take) begin
        acc <= merged;
        if (word_end) begin
          mem_we    <= 1'b1;
          mem_addr  <= word_addr;
          mem_wdata <= merged;
        end
        if (last) begin
          active <= 1'b0;
          off    <= '0;
          done   <= 1'b1;
        end else begin
          active <= 1'b1;
          off    <= cur_off + 1'b1;
        end
      end
    end
  end

  p_word_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[LANE_W-1:0] == '0));
  p_stop_on_disable_r8: assert property (@(posedge clk) disable iff (rst)
    abort |=> !mem_we);
  p_done_with_write_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> mem_we);
  p_drop_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    drop |-> (!mem_we && !done));
endmodule

// File: rtl/ts_slot_ptr.sv
module ts_slot_ptr #(
  parameter int SLOT_LEN = 192,
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_top,
  input  logic [ADDR_W-1:0] rd_ptr,
  input  logic              commit,
  input  logic              drop,
  output logic              room,
  output logic [ADDR_W-1:0] slot_base,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] occupancy,
  output logic              full,
  output logic [CNT_W-1:0]  ovf_count
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0]  sum_cur, sum_eff, size, diff, wrapped;
  logic [ADDR_W-1:0] wp_eff, nxt_eff, occ_next;

  always_comb begin
    sum_cur  = {1'b0, wr_ptr} + EXT_W'(SLOT_LEN);
    wp_eff   = commit ? ((sum_cur > {1'b0, cfg_top}) ? cfg_base : sum_cur[ADDR_W-1:0])
                      : wr_ptr;
    sum_eff  = {1'b0, wp_eff} + EXT_W'(SLOT_LEN);
    nxt_eff  = (sum_eff > {1'b0, cfg_top}) ? cfg_base : sum_eff[ADDR_W-1:0];
    room     = (nxt_eff != rd_ptr);
    slot_base = wp_eff;
    size     = {1'b0, cfg_top} - {1'b0, cfg_base} + EXT_W'(1);
    diff     = {1'b0, wp_eff} - {1'b0, rd_ptr};
    wrapped  = diff + size;
    occ_next = (wp_eff >= rd_ptr) ? diff[ADDR_W-1:0] : wrapped[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      occupancy <= '0;
      full      <= 1'b0;
      ovf_count <= '0;
    end else begin
      wr_ptr    <= cfg_load ? cfg_base : wp_eff;
      occupancy <= occ_next;
      full      <= !room;
      if (drop) ovf_count <= ovf_count + 1'b1;
    end
  end

  p_ptr_moves_on_event_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_ptr) |-> ($past(commit) || $past(cfg_load)));
  p_ovf_step_r6: assert property (@(posedge clk) disable iff (rst)
    drop |=> (ovf_count == $past(ovf_count) + 1'b1));
  p_no_commit_on_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (drop && !cfg_load) |=> (wr_ptr == $past(wr_ptr)));
endmodule

// File: rtl/ts_ring_writer.sv
module ts_ring_writer #(
  parameter int PKT_LEN    = 188,
  parameter int WORD_BYTES = 8,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    cfg_load,
  input  logic [ADDR_W-1:0]       cfg_base,
  input  logic [ADDR_W-1:0]       cfg_top,
  input  logic [ADDR_W-1:0]       rd_ptr,
  input  logic                    in_valid,
  input  logic                    in_sop,
  input  logic [7:0]              in_data,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_BYTES*8-1:0] mem_wdata,
  output logic [ADDR_W-1:0]       wr_ptr,
  output logic [ADDR_W-1:0]       occupancy,
  output logic                    full,
  output logic [CNT_W-1:0]        ovf_count
);
  localparam int SLOT_LEN = ts_ring_pkg::slot_bytes(PKT_LEN, WORD_BYTES);

  logic              abort, room, done, drop;
  logic [ADDR_W-1:0] slot_base;

  assign abort = !en || cfg_load;

  ts_word_packer #(
    .PKT_LEN(PKT_LEN), .WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W)
  ) u_packer (
    .clk(clk), .rst(rst), .abort(abort),
    .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .room(room), .slot_base(slot_base),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .drop(drop)
  );

  ts_slot_ptr #(
    .SLOT_LEN(SLOT_LEN), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_ptr (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .cfg_base(cfg_base), .cfg_top(cfg_top), .rd_ptr(rd_ptr),
    .commit(done), .drop(drop), .room(room), .slot_base(slot_base),
    .wr_ptr(wr_ptr), .occupancy(occupancy), .full(full), .ovf_count(ovf_count)
  );

  p_silent_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(en)) |-> !mem_we);
endmodule

// File: tb/ts_ring_writer_bench.sv
module ts_ring_writer_bench;
  localparam int ADDR_W = 16;
  localparam int SLOT   = 192;
  localparam int PKT    = 188;
  localparam logic [ADDR_W-1:0] BASE = 16'h0100;
  localparam logic [ADDR_W-1:0] TOP  = 16'h06FF;

  logic clk = 0;
  logic rst, en, cfg_load, in_valid, in_sop;
  logic [ADDR_W-1:0] cfg_base, cfg_top, rd_ptr;
  logic [7:0] in_data;
  logic mem_we;
  logic [ADDR_W-1:0] mem_addr, wr_ptr, occupancy;
  logic [63:0] mem_wdata;
  logic full;
  logic [15:0] ovf_count;

  int checks = 0;
  int failures = 0;
  logic we_after_last;
  logic [ADDR_W-1:0] wp_after_last;
  logic [7:0] mem [0:4095];

  always #5 clk = ~clk;

  ts_ring_writer u_ts_ring_writer (
    .clk(clk), .rst(rst), .en(en), .cfg_load(cfg_load),
    .cfg_base(cfg_base), .cfg_top(cfg_top), .rd_ptr(rd_ptr),
    .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wr_ptr(wr_ptr), .occupancy(occupancy), .full(full), .ovf_count(ovf_count)
  );

  always @(posedge clk)
    if (mem_we)
      for (int b = 0; b < 8; b++) mem[(int'(mem_addr) + b) % 4096] <= mem_wdata[b*8 +: 8];

  function automatic logic [7:0] pat(int tag, int i);
    return 8'(tag * 37 + i * 3 + 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic send_pkt(int tag, int len, bit gaps);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (i == 0); in_data = pat(tag, i);
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk);
        in_valid = 0; in_sop = 0;
      end
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0;
    we_after_last = mem_we;
    wp_after_last = wr_ptr;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // R1 R2 R3: whole-slot comparison, payload then zero fill
  task automatic check_slot(string req, int tag, logic [ADDR_W-1:0] start);
    int errs = 0;
    for (int i = 0; i < SLOT; i++) begin
      logic [7:0] e;
      e = (i < PKT) ? pat(tag, i) : 8'h00;
      if (mem[int'(start) + i] !== e) errs++;
    end
    chk(req, errs, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    int seen;
    for (int a = 0; a < 4096; a++) mem[a] = 8'hAA;
    rst = 1; en = 0; cfg_load = 0; in_valid = 0; in_sop = 0; in_data = 0;
    cfg_base = BASE; cfg_top = TOP; rd_ptr = BASE;
    settle(3);
    // R11 reset state
    chk("R11 mem_we", mem_we, 0);
    chk("R11 wr_ptr", wr_ptr, 0);
    chk("R11 occupancy", occupancy, 0);
    chk("R11 full", full, 0);
    chk("R11 ovf", ovf_count, 0);
    rst = 0;
    @(negedge clk); cfg_load = 1;
    @(negedge clk); cfg_load = 0; en = 1;
    settle(1);
    chk("R10 load to base", wr_ptr, BASE);
    chk("R7 empty occupancy", occupancy, 0);

    // R9 stray bytes without start are ignored
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (mem_we) seen++;
      in_valid = (i < 10); in_sop = 0; in_data = 8'(i);
    end
    chk("R9 stray bytes no write", seen, 0);
    chk("R9 stray bytes ptr", wr_ptr, BASE);

    // R1 R4 first packet
    send_pkt(1, PKT, 0);
    chk("R4 final word on port", we_after_last, 1);
    chk("R4 ptr not yet moved", wp_after_last, BASE);
    settle(1);
    chk("R1 ptr advance", wr_ptr, BASE + SLOT);
    check_slot("R3 slot0 content", 1, BASE);
    chk("R7 occupancy one slot", occupancy, SLOT);

    // fill slots 1..6, some with gaps
    for (int t = 2; t <= 7; t++) begin
      send_pkt(t, PKT, t[0]);
      settle(1);
    end
    chk("R1 seven slots", wr_ptr, BASE + 7 * SLOT);
    chk("R6 full flag", full, 1);
    chk("R7 occupancy seven", occupancy, 7 * SLOT);
    for (int t = 2; t <= 7; t++) check_slot("R2 slot content", t, BASE + ADDR_W'((t - 1) * SLOT));

    // R6 dropped packet
    send_pkt(8, PKT, 0);
    settle(1);
    chk("R6 overflow count", ovf_count, 1);
    chk("R6 ptr held", wr_ptr, BASE + 7 * SLOT);
    chk("R6 slot untouched a", mem[int'(BASE) + 7 * SLOT], 8'hAA);
    chk("R6 slot untouched b", mem[int'(BASE) + 7 * SLOT + 100], 8'hAA);

    // consumer reads three slots
    rd_ptr = BASE + 3 * SLOT;
    settle(2);
    chk("R6 not full", full, 0);
    chk("R7 occupancy positive", occupancy, 4 * SLOT);

    // R5 wrap on last slot
    send_pkt(9, PKT, 0);
    settle(1);
    chk("R5 wrap to base", wr_ptr, BASE);
    check_slot("R2 last slot content", 9, BASE + 7 * SLOT);
    chk("R7 occupancy wrapped", occupancy, 5 * SLOT);

    send_pkt(10, PKT, 0); settle(1);
    send_pkt(11, PKT, 1); settle(1);
    chk("R5 after wrap", wr_ptr, BASE + 2 * SLOT);
    chk("R6 full at read ptr", full, 1);
    chk("R7 occupancy near full", occupancy, 7 * SLOT);
    check_slot("R2 overwrite slot0", 10, BASE);
    check_slot("R2 overwrite slot1", 11, BASE + SLOT);
    chk("R6 no more drops", ovf_count, 1);

    // R8 disable mid-packet
    rd_ptr = BASE + 6 * SLOT;
    settle(2);
    seen = 0;
    for (int i = 0; i < PKT; i++) begin
      @(negedge clk);
      if (i >= 52 && mem_we) seen++;
      in_valid = 1; in_sop = (i == 0); in_data = pat(12, i);
      if (i == 50) en = 0;
    end
    @(negedge clk); in_valid = 0; in_sop = 0;
    if (mem_we) seen++;
    settle(2);
    chk("R8 no writes after disable", seen, 0);
    chk("R8 ptr unchanged", wr_ptr, BASE + 2 * SLOT);
    en = 1;

    // R9 restart in the middle of a packet
    send_pkt(13, 30, 0);
    send_pkt(14, PKT, 0);
    settle(1);
    chk("R9 restart one slot", wr_ptr, BASE + 3 * SLOT);
    check_slot("R9 restarted content", 14, BASE + 2 * SLOT);

    report();
    $finish;
  end
endmodule